// File: doc/BRIEF.md
# Programmable Dual-Modulus Cascade Divider

This block divides an input clock by any integer from 128 to 255. It does not compare one wide counter against a target. It chains seven small cells, and each cell divides the ticks it receives by two or by three. A modulus-control signal travels backward from the slowest cell to the fastest. Each cell adds its one extra input cycle exactly once per output period, and only when its own program bit is set. The total period is therefore 128 plus the binary value of the 7-bit word. Bit 0 steers the first, fastest cell and bit 6 steers the last.

The block gives one single-cycle pulse per completed period. It reads the program word only in the first input cycle of each period, so a modulator that changes the word every period never produces a period of mixed length. All cells are clocked by the input clock. A cell advances on the tick from the cell before it, so the structure and the arithmetic of the cascade are kept in fully synchronous logic.

Top module: `divchain`

## Requirements
- R1: While reset is held, `pulse_o` is low. The first output period begins with the first clock edge after reset is released and uses the word present in that first cycle.
- R2: Each output period lasts 128 + W input clock cycles, where W is the 7-bit word whose bit n carries weight 2^n.
- R3: Word 0 gives 128-cycle periods and word 127 (all ones) gives 255-cycle periods.
- R4: The word is taken in the cycle in which `pulse_o` is high, which is the first cycle of a period. A change at any other time has no effect on the period in progress.
- R5: `pulse_o` is high for exactly one input cycle per period, in the cycle right after the last cycle of the period.
- R6: A cell lengthens its output by one input cycle only when its program bit is 1 and its incoming modulus control is active, and this happens once per period. A word with a single bit n set therefore gives 128 + 2^n. The modulus control reaching the first cell forms one contiguous window per period.
- R7: With word 22 (ratio 150) and a 5 ns input period, output pulses are 750 ns apart. At a 2.4 GHz input this ratio gives a 16 MHz output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 7 | Program word; ratio is 128 plus this value |
| pulse_o | output | 1 | One-cycle pulse marking each completed period |

## Verification
A fault in one cell's phase counter or in its modulus-control gating changes the length of the period that contains the fault. It appears as a pulse spacing different from 128 + W, which is visible at the next `pulse_o`, at most 255 input cycles later. A stuck cell shows as a spacing of exactly 128 + W ± 2^n, and a walking-one word picks out the cell responsible. A word register that captures at the wrong time shows as a period with the length of a word that was driven in mid-period.

// File: rtl/divchain_pkg.sv
package divchain_pkg;

  // Number of 2/3 cells in the cascade by default.
  localparam int unsigned DC_STAGES = 7;

  // Width of a cell's phase counter (counts up to 2).
  localparam int unsigned DC_PH_W = 2;

  // Division ratio for a given word: 2^stages plus the word.
  function automatic int unsigned dc_ratio(input int unsigned word,
                                           input int unsigned stages);
    int unsigned base;
    base = 32'd1 << stages;
    return base + (word & (base - 1));
  endfunction

  // Index of the last phase of a cell's output cycle:
  // 1 for a divide-by-2 cycle, 2 for a divide-by-3 cycle.
  function automatic logic [DC_PH_W-1:0] dc_last_phase(input logic bit_i,
                                                       input logic mod_i);
    return (bit_i && mod_i) ? DC_PH_W'(2) : DC_PH_W'(1);
  endfunction

endpackage

// File: rtl/dc_mod23_cell.sv
module dc_mod23_cell
  import divchain_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,   // one input period of this cell elapses
  input  logic mod_i,    // modulus control from the next (slower) cell
  input  logic bit_i,    // program bit for this cell
  output logic tick_o,   // one output period of this cell completes
  output logic mod_o     // modulus control toward the previous cell
);

  logic [DC_PH_W-1:0] phase_q;
  logic [DC_PH_W-1:0] last_ph;
  logic               at_last;

  assign last_ph = dc_last_phase(bit_i, mod_i);
  assign at_last = (phase_q >= last_ph);

  // Output cycle ends on the tick seen during the last phase.
  assign tick_o = tick_i && at_last;

  // Control goes back only during this cell's last input period,
  // and only when this cell is itself being steered.
  assign mod_o = mod_i && at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
    end else if (tick_i) begin
      if (at_last) phase_q <= '0;
      else         phase_q <= phase_q + DC_PH_W'(1);
    end
  end

endmodule

// File: rtl/dc_word_sampler.sv
module dc_word_sampler #(
  parameter int unsigned WIDTH = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,   // first cycle of an output period
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] word_o,    // word in force for this period
  output logic [WIDTH-1:0] held_o     // registered copy
);

  logic [WIDTH-1:0] held_q;

  // In the first cycle the live word is used; afterwards the copy
  // taken in that cycle holds for the rest of the period.
  assign word_o = start_i ? word_i : held_q;
  assign held_o = held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= '0;
    else         held_q <= word_o;
  end

endmodule

// File: rtl/divchain.sv
module divchain
  import divchain_pkg::*;
#(
  parameter int unsigned STAGES = DC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAGES-1:0] word_i,
  output logic              pulse_o
);

  // ticks[i] drives cell i; ticks[STAGES] marks the end of a period.
  logic [STAGES:0]   ticks;
  // mods[i] is the control leaving cell i; mods[STAGES] is tied on.
  logic [STAGES:0]   mods;
  logic [STAGES-1:0] word_eff;
  logic [STAGES-1:0] word_q;
  logic              start_q;
  logic              pulse_q;
  logic              period_end;

  assign ticks[0]      = 1'b1;
  assign mods[STAGES]  = 1'b1;
  assign period_end    = ticks[STAGES];

  dc_word_sampler #(.WIDTH(STAGES)) u_word (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_q),
    .word_i  (word_i),
    .word_o  (word_eff),
    .held_o  (word_q)
  );

  for (genvar g = 0; g < STAGES; g++) begin : g_cell
    dc_mod23_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (ticks[g]),
      .mod_i  (mods[g+1]),
      .bit_i  (word_eff[g]),
      .tick_o (ticks[g+1]),
      .mod_o  (mods[g])
    );
  end

  // start_q marks the first cycle of each period, including the
  // first cycle after reset.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      start_q <= period_end;
      pulse_q <= period_end;
    end
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/divchain_chk.sv
module divchain_chk
  import divchain_pkg::*;
#(
  parameter int unsigned STAGES = DC_STAGES
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pulse_i,
  input logic              start_i,
  input logic [STAGES-1:0] word_q_i,
  input logic [STAGES:0]   ticks_i,
  input logic [STAGES:0]   mods_i
);

  localparam int unsigned MIN_LEN = dc_ratio(0, STAGES);
  localparam int unsigned MAX_LEN = dc_ratio((32'd1 << STAGES) - 1, STAGES);

  logic [15:0] gap_q;
  logic        mod0_d;
  logic [3:0]  runs_q;
  logic [3:0]  runs_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gap_q <= '0;
    else         gap_q <= pulse_i ? 16'd1 : gap_q + 16'd1;
  end

  assign runs_now = runs_q + {3'd0, (mods_i[0] && !mod0_d)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod0_d <= 1'b0;
      runs_q <= '0;
    end else begin
      mod0_d <= mods_i[0];
      runs_q <= ticks_i[STAGES] ? 4'd0 : runs_now;
    end
  end

  // R5
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> !pulse_i);

  // R2
  period_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |-> (gap_q >= 16'(MIN_LEN) && gap_q <= 16'(MAX_LEN)));

  // R4
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(word_q_i));

  // R6
  mod_window_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ticks_i[STAGES] |-> (runs_now == 4'd1));

endmodule

bind divchain divchain_chk #(.STAGES(STAGES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pulse_i  (pulse_o),
  .start_i  (start_q),
  .word_q_i (word_q),
  .ticks_i  (ticks),
  .mods_i   (mods)
);

// File: tb/sim_divchain.sv
`timescale 1ns/1ps
module sim_divchain;
  localparam int S = 7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [S-1:0] word = '0;
  logic         pulse;

  always #2.5 clk = ~clk;

  divchain #(.STAGES(S)) u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .word_i  (word),
    .pulse_o (pulse)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    exp_q[$];
  int    wrd_q[$];
  string lab_q[$];

  // Expected length: the word with a leading one placed above it.
  function automatic int expect_len(input logic [S-1:0] w);
    return int'({1'b1, w});
  endfunction

  task automatic check(input bit ok, input string req,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [S-1:0] w, input string lab);
    word = w;
    exp_q.push_back(expect_len(w));
    wrd_q.push_back(int'(w));
    lab_q.push_back(lab);
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!pulse);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // Driver
  initial begin
    logic [S-1:0] plan [10];
    plan = '{7'd0, 7'd127, 7'd1, 7'd2, 7'd4, 7'd8, 7'd16, 7'd32, 7'd64, 7'd22};
    push(7'd22, "R1");
    repeat (4) @(negedge clk);
    check(pulse == 1'b0, "R1 pulse during reset", int'(pulse), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 40; k++) begin
      logic [S-1:0] w;
      string        lab;
      w   = (k < 10) ? plan[k] : S'($urandom_range(127, 0));
      lab = (k < 2) ? "R3" : (k < 9) ? "R6" : (k == 9) ? "R7" : "R2";
      wait_pulse();
      if (k >= 10 && (k % 3) == 1) lab = "R4";
      push(w, lab);
      if (lab == "R4") begin
        repeat (37) @(negedge clk);
        word = ~w;
      end
    end
    wait_pulse();
    @(negedge clk);
    finish_run();
  end

  // Monitor
  initial begin
    int  cnt;
    real t0;
    @(posedge rst_n);
    cnt = 0;
    t0  = $realtime;
    forever begin
      @(negedge clk);
      cnt++;
      if (cnt == 1 && n_chk > 1)
        check(pulse == 1'b0, "R5 pulse width", int'(pulse), 0);
      if (pulse) begin
        if (exp_q.size() > 0) begin
          int    e;
          int    w;
          string l;
          e = exp_q.pop_front();
          w = wrd_q.pop_front();
          l = lab_q.pop_front();
          check(cnt == e, $sformatf("%s period word=%0d", l, w), cnt, e);
          if (e == 150)
            check(int'($realtime - t0) == 750, "R7 spacing ns",
                  int'($realtime - t0), 750);
        end
        cnt = 0;
        t0  = $realtime;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end

endmodule